// File: doc/BRIEF.md
# Two-Level Privilege Mode Controller

This block keeps the privilege level of a hart that knows only two levels, machine and user. It takes single-cycle event pulses from the pipeline: a general trap with its exception code, an environment call and a trap return. From these it updates the current level, the saved previous level and the cause value, and it raises a one-cycle flush request whenever a trap is taken. It also owns the privilege-related bits of the machine status register. The saved level is held in one inverted flip-flop, so it reads as machine right after reset. For machine-mode data accesses, a status bit can make loads and stores run at the saved level.

A small registered read port returns the machine status privilege bits, the read-only ISA description word and the all-zero environment configuration pair. All state is synchronous, with an active-high reset. The pipeline drives at most one kind of event per cycle in normal use, and a fixed priority settles any overlap.

Top module: `priv_mode_ctrl`

## Requirements
- R1: After reset, mode_o is 2'b11 (machine), the saved level reads 2'b11, the modify-privilege bit is 0, and flush_o and cause_o are 0.
- R2: A trap_i pulse sets mode_o to machine on the next cycle. On that same cycle it loads cause_o with exc_code_i, stores the level active before the trap as the saved level, and raises flush_o for exactly one cycle.
- R3: An ecall_i pulse is taken as a trap with cause 11 when the current mode is machine and cause 8 when it is user.
- R4: mret_i in machine mode sets the mode to the saved level and then sets the saved level to user. The modify-privilege bit is cleared only when the return goes to user. No flush is raised.
- R5: mret_i in user mode is taken as an illegal-instruction trap with cause 2, and the mode is not lowered.
- R6: Priority is trap_i over ecall_i over mret_i. Any of the three in a cycle blocks a status-register write in that cycle.
- R7: A write to address 0x300 sets the saved level from wdata[12:11]: 2'b11 gives machine, any other value gives user. The same write sets the modify-privilege bit from wdata[17]. All other bits are ignored and read as 0.
- R8: Address 0x301 reads 0x40100100 (32-bit width, base integer set, user-level bit 20 set) and ignores writes.
- R9: Addresses 0x30A and 0x31A read all zeros and ignore writes. Any other address also reads zero.
- R10: dpriv_o equals the saved level when the modify-privilege bit is set and the mode is machine. Otherwise it equals mode_o.
- R11: csr_rdata_o shows, one cycle later, the value at csr_raddr_i as the state stood before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_i | input | 1 | Trap entry pulse |
| exc_code_i | input | XLEN | Cause code that goes with trap_i |
| ecall_i | input | 1 | Environment call pulse |
| mret_i | input | 1 | Trap return pulse |
| csr_we_i | input | 1 | Status write strobe |
| csr_waddr_i | input | AW | Write address |
| csr_wdata_i | input | XLEN | Write data |
| csr_raddr_i | input | AW | Read address |
| mode_o | output | 2 | Current level (2'b11 machine, 2'b00 user) |
| dpriv_o | output | 2 | Level used by loads and stores |
| cause_o | output | XLEN | Last trap cause |
| flush_o | output | 1 | One-cycle pipeline flush request |
| csr_rdata_o | output | XLEN | Registered read data |

## Verification
Every result of this block lands one edge after its stimulus. An event or write presented before an edge shows on mode_o, cause_o, flush_o and the saved level just after that edge. dpriv_o follows the registered state with no extra delay. csr_rdata_o holds the pre-edge value of the address sampled at that edge. The bench drives inputs at the falling edge and updates its behavioural model at the rising edge. At the next falling edge it compares every output against the model, so each comparison falls exactly one register stage after its cause.

// File: rtl/priv_pkg.sv
package priv_pkg;
  typedef enum logic [1:0] {PRIV_U = 2'b00, PRIV_M = 2'b11} priv_e;

  localparam logic [11:0] ADR_STATUS  = 12'h300;
  localparam logic [11:0] ADR_ISA     = 12'h301;
  localparam logic [11:0] ADR_ENVLO   = 12'h30A;
  localparam logic [11:0] ADR_ENVHI   = 12'h31A;

  localparam int SAVED_LO  = 11;
  localparam int SAVED_HI  = 12;
  localparam int MODIFY_BIT = 17;

  localparam int CODE_ILLEGAL = 2;
  localparam int CODE_CALL_U  = 8;
  localparam int CODE_CALL_M  = 11;
endpackage

// File: rtl/priv_event.sv
module priv_event
  import priv_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 12
) (
  input  logic            in_machine,
  input  logic            trap_i,
  input  logic [XLEN-1:0] exc_code_i,
  input  logic            ecall_i,
  input  logic            mret_i,
  input  logic            csr_we_i,
  input  logic [AW-1:0]   csr_waddr_i,
  output logic            take_trap,
  output logic [XLEN-1:0] trap_cause,
  output logic            take_ret,
  output logic            status_we
);
  logic any_event;

  always_comb begin
    any_event  = trap_i | ecall_i | mret_i;
    take_trap  = trap_i | ecall_i | (mret_i & ~in_machine);
    take_ret   = mret_i & in_machine & ~trap_i & ~ecall_i;
    status_we  = csr_we_i & (csr_waddr_i == AW'(ADR_STATUS)) & ~any_event;
    if (trap_i)
      trap_cause = exc_code_i;
    else if (ecall_i)
      trap_cause = in_machine ? XLEN'(CODE_CALL_M) : XLEN'(CODE_CALL_U);
    else
      trap_cause = XLEN'(CODE_ILLEGAL);
  end
endmodule

// File: rtl/priv_state.sv
module priv_state #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take_trap,
  input  logic [XLEN-1:0] trap_cause,
  input  logic            take_ret,
  input  logic            status_we,
  input  logic [1:0]      wr_saved,
  input  logic            wr_modify,
  output logic            in_machine,
  output logic            saved_machine,
  output logic            modify_on,
  output logic [XLEN-1:0] cause_o,
  output logic            flush_o
);
  // saved level kept inverted: 0 after reset means machine
  logic saved_inv;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_machine <= 1'b1;
      saved_inv  <= 1'b0;
      modify_on  <= 1'b0;
      cause_o    <= '0;
      flush_o    <= 1'b0;
    end else begin
      flush_o <= take_trap;
      if (take_trap) begin
        in_machine <= 1'b1;
        saved_inv  <= ~in_machine;
        cause_o    <= trap_cause;
      end else if (take_ret) begin
        in_machine <= ~saved_inv;
        saved_inv  <= 1'b1;
        if (saved_inv) modify_on <= 1'b0;
      end else if (status_we) begin
        saved_inv <= ~(wr_saved == 2'b11);
        modify_on <= wr_modify;
      end
    end
  end

  assign saved_machine = ~saved_inv;

  assert_trap_to_machine_R2: assert property (@(posedge clk) disable iff (rst)
    take_trap |=> (in_machine && flush_o));
  assert_flush_only_after_trap_R2: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> $past(take_trap));
  assert_ret_restores_R4: assert property (@(posedge clk) disable iff (rst)
    take_ret |=> (in_machine == $past(saved_machine)) && !saved_machine);
  assert_ret_user_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (take_ret && !saved_machine) |=> !modify_on);
endmodule

// File: rtl/priv_csr_rd.sv
module priv_csr_rd
  import priv_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          AW       = 12,
  parameter logic [25:0] ISA_EXT  = 26'h0000100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   csr_raddr_i,
  input  logic            saved_machine,
  input  logic            modify_on,
  output logic [XLEN-1:0] csr_rdata_o
);
  localparam logic [25:0]     EXT_ALL = ISA_EXT | 26'(1 << 20);
  localparam logic [XLEN-1:0] ISA_VAL = {2'b01, {(XLEN-28){1'b0}}, EXT_ALL};

  logic [XLEN-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    case (csr_raddr_i)
      AW'(ADR_STATUS): begin
        rd_val[SAVED_HI:SAVED_LO] = {2{saved_machine}};
        rd_val[MODIFY_BIT]        = modify_on;
      end
      AW'(ADR_ISA): rd_val = ISA_VAL;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) csr_rdata_o <= '0;
    else     csr_rdata_o <= rd_val;
  end

  assert_env_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    ((csr_raddr_i == AW'(ADR_ENVLO)) || (csr_raddr_i == AW'(ADR_ENVHI))) |=> (csr_rdata_o == '0));
endmodule

// File: rtl/priv_mode_ctrl.sv
module priv_mode_ctrl
  import priv_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter int          AW      = 12,
  parameter logic [25:0] ISA_EXT = 26'h0000100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trap_i,
  input  logic [XLEN-1:0] exc_code_i,
  input  logic            ecall_i,
  input  logic            mret_i,
  input  logic            csr_we_i,
  input  logic [AW-1:0]   csr_waddr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  input  logic [AW-1:0]   csr_raddr_i,
  output logic [1:0]      mode_o,
  output logic [1:0]      dpriv_o,
  output logic [XLEN-1:0] cause_o,
  output logic            flush_o,
  output logic [XLEN-1:0] csr_rdata_o
);
  logic            in_machine, saved_machine, modify_on;
  logic            take_trap, take_ret, status_we;
  logic [XLEN-1:0] trap_cause;
  logic            unused_wbits;

  assign unused_wbits = ^{csr_wdata_i[XLEN-1:MODIFY_BIT+1],
                          csr_wdata_i[MODIFY_BIT-1:SAVED_HI+1],
                          csr_wdata_i[SAVED_LO-1:0]};

  priv_event #(.XLEN(XLEN), .AW(AW)) u_event (
    .in_machine (in_machine),
    .trap_i     (trap_i),
    .exc_code_i (exc_code_i),
    .ecall_i    (ecall_i),
    .mret_i     (mret_i),
    .csr_we_i   (csr_we_i),
    .csr_waddr_i(csr_waddr_i),
    .take_trap  (take_trap),
    .trap_cause (trap_cause),
    .take_ret   (take_ret),
    .status_we  (status_we)
  );

  priv_state #(.XLEN(XLEN)) u_state (
    .clk          (clk),
    .rst          (rst),
    .take_trap    (take_trap),
    .trap_cause   (trap_cause),
    .take_ret     (take_ret),
    .status_we    (status_we),
    .wr_saved     (csr_wdata_i[SAVED_HI:SAVED_LO]),
    .wr_modify    (csr_wdata_i[MODIFY_BIT]),
    .in_machine   (in_machine),
    .saved_machine(saved_machine),
    .modify_on    (modify_on),
    .cause_o      (cause_o),
    .flush_o      (flush_o)
  );

  priv_csr_rd #(.XLEN(XLEN), .AW(AW), .ISA_EXT(ISA_EXT)) u_rd (
    .clk          (clk),
    .rst          (rst),
    .csr_raddr_i  (csr_raddr_i),
    .saved_machine(saved_machine),
    .modify_on    (modify_on),
    .csr_rdata_o  (csr_rdata_o)
  );

  assign mode_o  = in_machine ? PRIV_M : PRIV_U;
  assign dpriv_o = (modify_on && in_machine) ? (saved_machine ? PRIV_M : PRIV_U) : mode_o;

  assert_ecall_user_cause_R3: assert property (@(posedge clk) disable iff (rst)
    (ecall_i && !trap_i && mode_o == PRIV_U) |=> (cause_o == XLEN'(CODE_CALL_U)));
  assert_user_data_level_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_o == PRIV_U) |-> (dpriv_o == PRIV_U));
  assert_user_ret_illegal_R5: assert property (@(posedge clk) disable iff (rst)
    (mret_i && !trap_i && !ecall_i && mode_o == PRIV_U) |=> (cause_o == XLEN'(CODE_ILLEGAL)) && flush_o);
endmodule

// File: tb/tb_priv_mode_ctrl.sv
module tb_priv_mode_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trap_i = 0, ecall_i = 0, mret_i = 0, csr_we_i = 0;
  logic [31:0] exc_code_i = 0, csr_wdata_i = 0;
  logic [11:0] csr_waddr_i = 0, csr_raddr_i = 0;
  logic [1:0]  mode_o, dpriv_o;
  logic [31:0] cause_o, csr_rdata_o;
  logic        flush_o;

  always #4 clk = ~clk;

  priv_mode_ctrl dut (
    .clk(clk), .rst(rst), .trap_i(trap_i), .exc_code_i(exc_code_i),
    .ecall_i(ecall_i), .mret_i(mret_i), .csr_we_i(csr_we_i),
    .csr_waddr_i(csr_waddr_i), .csr_wdata_i(csr_wdata_i),
    .csr_raddr_i(csr_raddr_i), .mode_o(mode_o), .dpriv_o(dpriv_o),
    .cause_o(cause_o), .flush_o(flush_o), .csr_rdata_o(csr_rdata_o)
  );

  int checks = 0, fails = 0;
  bit started = 0, done = 0;
  // behavioural model state
  bit m_mach, m_saved, m_mod, m_flush;
  logic [31:0] m_cause, m_rdata;
  string tag = "R1";

  function automatic logic [31:0] model_read(logic [11:0] a);
    logic [31:0] v = 0;
    if (a == 12'h300) begin v[12:11] = m_saved ? 2'b11 : 2'b00; v[17] = m_mod; end
    else if (a == 12'h301) v = 32'h40100100;
    return v;
  endfunction

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_mach = 1; m_saved = 1; m_mod = 0; m_flush = 0; m_cause = 0; m_rdata = 0;
      tag = "R1"; started = 1;
    end else begin
      m_rdata = model_read(csr_raddr_i);
      m_flush = 0;
      tag = (csr_raddr_i == 12'h301) ? "R8" :
            (csr_raddr_i == 12'h30A || csr_raddr_i == 12'h31A) ? "R9" : "R11";
      if (trap_i) begin
        tag = (ecall_i || mret_i) ? "R6" : "R2";
        m_saved = m_mach; m_mach = 1; m_flush = 1; m_cause = exc_code_i;
      end else if (ecall_i) begin
        tag = mret_i ? "R6" : "R3";
        m_cause = m_mach ? 11 : 8;
        m_saved = m_mach; m_mach = 1; m_flush = 1;
      end else if (mret_i) begin
        if (m_mach) begin
          tag = csr_we_i ? "R6" : "R4";
          m_mach = m_saved;
          if (!m_saved) m_mod = 0;
          m_saved = 0;
        end else begin
          tag = "R5";
          m_saved = 0; m_mach = 1; m_flush = 1; m_cause = 2;
        end
      end else if (csr_we_i) begin
        if (csr_waddr_i == 12'h300) begin
          tag = "R7";
          m_saved = (csr_wdata_i[12:11] == 2'b11);
          m_mod = csr_wdata_i[17];
        end else tag = "R9";
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      check({tag, " mode"},  {30'b0, mode_o},  {30'b0, m_mach ? 2'b11 : 2'b00});
      check({tag, " flush"}, {31'b0, flush_o}, {31'b0, m_flush});
      check({tag, " cause"}, cause_o, m_cause);
      check({tag, " rdata"}, csr_rdata_o, m_rdata);
      check("R10 dpriv", {30'b0, dpriv_o},
            {30'b0, (m_mod && m_mach) ? (m_saved ? 2'b11 : 2'b00) : (m_mach ? 2'b11 : 2'b00)});
    end
  end

  task automatic drive(bit tr, logic [31:0] code, bit ec, bit mr, bit we,
                       logic [11:0] wa, logic [31:0] wd, logic [11:0] ra);
    @(negedge clk);
    trap_i = tr; exc_code_i = code; ecall_i = ec; mret_i = mr;
    csr_we_i = we; csr_waddr_i = wa; csr_wdata_i = wd; csr_raddr_i = ra;
  endtask

  task automatic idle(logic [11:0] ra);
    drive(0, 0, 0, 0, 0, 0, 0, ra);
  endtask

  function automatic logic [11:0] pick_addr(int k);
    case (k % 5)
      0: return 12'h300; 1: return 12'h301; 2: return 12'h30A;
      3: return 12'h31A; default: return 12'h123;
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values seen on the first cycle after release
    check("R1 mode", {30'b0, mode_o}, 32'd3);
    check("R1 cause", cause_o, 0);
    rst = 0;
    idle(12'h300);                       // R1 saved level reads 11
    idle(12'h301);                       // R8
    idle(12'h30A); idle(12'h31A); idle(12'h123); // R9
    drive(0, 0, 0, 0, 1, 12'h300, 32'hFFFD_E7FF, 12'h300); // R7 saved=U, mod=0, junk bits
    drive(0, 0, 0, 0, 1, 12'h300, 32'h0002_0000, 12'h300); // R7 mod=1 saved=U
    idle(12'h300);                        // R10 dpriv = U while machine
    drive(0, 0, 0, 1, 0, 0, 0, 12'h300);  // R4 return to user, mod cleared
    idle(12'h300);
    drive(0, 0, 1, 0, 0, 0, 0, 12'h300);  // R3 cause 8
    drive(0, 0, 0, 1, 0, 0, 0, 12'h300);  // R4 to user
    drive(0, 0, 0, 1, 0, 0, 0, 12'h300);  // R5 illegal in user
    drive(1, 32'd5, 0, 0, 0, 0, 0, 12'h300); // R2 code 5 in machine
    drive(0, 0, 1, 0, 0, 0, 0, 12'h300);  // R3 cause 11
    drive(0, 0, 0, 0, 1, 12'h300, 32'h0000_0800, 12'h300); // R7 01 -> user
    drive(0, 0, 0, 0, 1, 12'h300, 32'h0002_1800, 12'h300); // R7 11 -> machine, mod=1
    drive(0, 0, 0, 1, 0, 0, 0, 12'h300);  // R4 return to machine, mod kept
    drive(1, 32'd7, 1, 1, 0, 0, 0, 12'h300); // R6 trap wins
    drive(0, 0, 1, 1, 0, 0, 0, 12'h300);  // R6 ecall beats mret
    drive(0, 0, 0, 1, 1, 12'h300, 32'h0002_1800, 12'h300); // R6 write blocked
    drive(0, 0, 0, 0, 1, 12'h301, 32'h0, 12'h301);        // R8 write ignored
    drive(0, 0, 0, 0, 1, 12'h30A, 32'hFFFF_FFFF, 12'h30A); // R9
    drive(0, 0, 0, 0, 1, 12'h31A, 32'hFFFF_FFFF, 12'h31A); // R9
    idle(12'h301); idle(12'h30A); idle(12'h31A);
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom % 16;
      drive(r == 0 || r == 9, $urandom % 16, r == 1 || r == 9, (r >= 2 && r <= 4) || r == 10,
            r >= 5 && r <= 8 || r == 10, (r == 5 || r == 10) ? 12'h300 : pick_addr($urandom),
            $urandom, pick_addr($urandom));
    end
    idle(12'h300); idle(12'h300);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule